// File: doc/BRIEF.md
# Four-Cycle Asynchronous SRAM Controller

This block connects a single-clock user interface to an external asynchronous static RAM. Each read or write occupies exactly four cycles of the system clock. The user side is a request strobe qualified by a ready flag, together with a direction bit, an address and write data. A read returns its data with a one-cycle valid pulse. On the memory side the block drives an address bus, active-low write and output strobes, and a data bus that is split into an output value, a drive enable and an input value, so that a pad tri-state can sit outside the block.

All memory-facing pins come straight from flops clocked on the rising edge. The phase counter is clocked on that same edge, so no pin path runs through falling-edge state or a combinational output stage, and every strobe edge is free of glitches. An optional self-check mode follows each write with a read-back of the same location. When the data does not match, the error output goes high for a programmable number of cycles, which is long enough to drive an indicator.

Top module: `sram4_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, sram_we_no and sram_oe_no are 1, sram_dq_oe_o is 0, ready_o is 1, and rvalid_o and err_o are 0. Reset also abandons an access in progress, and a write cut short in this way stores nothing.
- R2: A write holds sram_oe_no at 1 for all four phases. In phase 1 the address is set with sram_we_no at 1 and sram_dq_oe_o at 0. In phases 2 and 3 sram_we_no is 0 and sram_dq_o carries the write data. In phase 4 sram_we_no is back at 1.
- R3: A read holds sram_oe_no at 0 and sram_we_no at 1 for all four phases, and keeps sram_dq_oe_o at 0 throughout.
- R4: Every access lasts exactly four cycles. ready_o is 0 in phases 1 to 3 and 1 when idle or in phase 4. A request presented in phase 4 starts its phase 1 on the next cycle, with no idle cycle in between.
- R5: A read returns the value found on sram_dq_i at the end of phase 3. rvalid_o is 1 for exactly one cycle, in phase 4, and rdata_o keeps that value until the next read completes.
- R6: A request made while ready_o is 0 is ignored. It starts no access and does not change the address in use.
- R7: The address, write data and direction are captured when a request is accepted and stay on the pins for the whole access, whatever the inputs do afterwards.
- R8: When selfcheck_i is 1 at the acceptance of a write, ready_o stays 0 in that write's phase 4. A four-cycle read of the same address follows at once, and this read produces no rvalid_o pulse.
- R9: If the self-check read returns data that differs from the written data, err_o goes to 1 in that read's phase 4 and stays at 1 for exactly ERR_CYCLES cycles. If the data matches, err_o stays at 0.
- R10: sram_dq_oe_o is 1 only while sram_we_no is 0, and the two strobes are never both 0 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, taken when ready_o is 1 |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Access address |
| wdata_i | input | DATA_W | Write data |
| selfcheck_i | input | 1 | Enables read-back after each write |
| ready_o | output | 1 | Controller can accept a request this cycle |
| rdata_o | output | DATA_W | Last read data |
| rvalid_o | output | 1 | One-cycle read completion pulse |
| err_o | output | 1 | Self-check mismatch indication |
| sram_addr_o | output | ADDR_W | Memory address bus |
| sram_dq_o | output | DATA_W | Data to drive onto the memory bus |
| sram_dq_oe_o | output | 1 | Drive enable for the memory data bus |
| sram_dq_i | input | DATA_W | Data sampled from the memory bus |
| sram_we_no | output | 1 | Write strobe, active low |
| sram_oe_no | output | 1 | Output enable, active low |

## Verification
The bench targets back-to-back requests at the phase-4 boundary, where an extra idle cycle or a lost request would appear. It checks stray requests made while busy, which a design with a bad ready qualifier would accept as new accesses. It changes the inputs during an access, so a design that failed to hold its captured values would show a moving address or data. It also compares write-strobe timing against data-drive timing, which exposes bus contention or a write pulse that is too short. In self-check mode it forces a read-back mismatch and measures the error pulse width. Finally, it cuts a write short with reset and confirms that the target location is unchanged.

// File: rtl/sram4_pkg.sv
package sram4_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_1    = 3'd1,
    PH_2    = 3'd2,
    PH_3    = 3'd3,
    PH_4    = 3'd4
  } phase_e;

  // write strobe window: phases 2 and 3
  function automatic logic in_strobe(phase_e ph);
    return (ph == PH_2) || (ph == PH_3);
  endfunction
endpackage

// File: rtl/sram4_seq.sv
module sram4_seq
  import sram4_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   req_i,
  input  logic   we_i,
  input  logic   selfcheck_i,
  output phase_e phase_o,
  output phase_e phase_nxt_o,
  output logic   wr_o,
  output logic   wr_nxt_o,
  output logic   vfy_o,
  output logic   accept_o,
  output logic   ready_o
);
  phase_e phase_q, phase_d;
  logic   wr_q, wr_d, chk_q, chk_d, vfy_q, vfy_d;
  logic   vfy_pend, start_vfy, ready, accept;

  always_comb begin
    vfy_pend  = wr_q & chk_q;
    ready     = (phase_q == PH_IDLE) || ((phase_q == PH_4) && !vfy_pend);
    accept    = req_i & ready;
    start_vfy = (phase_q == PH_4) && vfy_pend;
  end

  always_comb begin
    wr_d  = wr_q;
    chk_d = chk_q;
    vfy_d = vfy_q;
    if (accept) begin
      phase_d = PH_1;
      wr_d    = we_i;
      chk_d   = we_i & selfcheck_i;
      vfy_d   = 1'b0;
    end else if (start_vfy) begin
      phase_d = PH_1;
      wr_d    = 1'b0;
      chk_d   = 1'b0;
      vfy_d   = 1'b1;
    end else begin
      unique case (phase_q)
        PH_1:    phase_d = PH_2;
        PH_2:    phase_d = PH_3;
        PH_3:    phase_d = PH_4;
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      wr_q    <= 1'b0;
      chk_q   <= 1'b0;
      vfy_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      wr_q    <= wr_d;
      chk_q   <= chk_d;
      vfy_q   <= vfy_d;
    end
  end

  assign phase_o     = phase_q;
  assign phase_nxt_o = phase_d;
  assign wr_o        = wr_q;
  assign wr_nxt_o    = wr_d;
  assign vfy_o       = vfy_q;
  assign accept_o    = accept;
  assign ready_o     = ready;
endmodule

// File: rtl/sram4_pins.sv
module sram4_pins
  import sram4_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  phase_e            phase_nxt_i,
  input  logic              wr_nxt_i,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wd_o,
  output logic              dq_oe_o,
  output logic              we_no,
  output logic              oe_no
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wd_q;
  logic              dq_oe_q, we_nq, oe_nq;

  // captured operands, held for the whole access
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      wd_q   <= '0;
    end else if (accept_i) begin
      addr_q <= addr_i;
      wd_q   <= wdata_i;
    end
  end

  // strobes registered from the next phase so they switch on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_nq   <= 1'b1;
      oe_nq   <= 1'b1;
      dq_oe_q <= 1'b0;
    end else begin
      we_nq   <= !(wr_nxt_i && in_strobe(phase_nxt_i));
      dq_oe_q <= wr_nxt_i && in_strobe(phase_nxt_i);
      oe_nq   <= !((phase_nxt_i != PH_IDLE) && !wr_nxt_i);
    end
  end

  assign addr_o  = addr_q;
  assign wd_o    = wd_q;
  assign dq_oe_o = dq_oe_q;
  assign we_no   = we_nq;
  assign oe_no   = oe_nq;
endmodule

// File: rtl/sram4_chk.sv
module sram4_chk
  import sram4_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ERR_CYCLES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  phase_e            phase_i,
  input  logic              wr_i,
  input  logic              vfy_i,
  input  logic [DATA_W-1:0] dq_i,
  input  logic [DATA_W-1:0] wd_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              err_o
);
  localparam int CW = $clog2(ERR_CYCLES + 1);

  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q, cap;
  logic [CW-1:0]     cnt_q;

  assign cap = (phase_i == PH_3) && !wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= cap && !vfy_i;
      if (cap && !vfy_i) rdata_q <= dq_i;
    end
  end

  // blink stretcher
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (cap && vfy_i && dq_i != wd_i) cnt_q <= CW'(ERR_CYCLES);
    else if (cnt_q != '0)                cnt_q <= cnt_q - CW'(1);
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
  assign err_o    = (cnt_q != '0);
endmodule

// File: rtl/sram4_ctrl.sv
module sram4_ctrl
  import sram4_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int DATA_W     = 16,
  parameter int ERR_CYCLES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              selfcheck_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              err_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe_o,
  input  logic [DATA_W-1:0] sram_dq_i,
  output logic              sram_we_no,
  output logic              sram_oe_no
);
  phase_e phase, phase_nxt;
  logic   wr, wr_nxt, vfy, accept;

  sram4_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .we_i        (we_i),
    .selfcheck_i (selfcheck_i),
    .phase_o     (phase),
    .phase_nxt_o (phase_nxt),
    .wr_o        (wr),
    .wr_nxt_o    (wr_nxt),
    .vfy_o       (vfy),
    .accept_o    (accept),
    .ready_o     (ready_o)
  );

  sram4_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .phase_nxt_i (phase_nxt),
    .wr_nxt_i    (wr_nxt),
    .accept_i    (accept),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .addr_o      (sram_addr_o),
    .wd_o        (sram_dq_o),
    .dq_oe_o     (sram_dq_oe_o),
    .we_no       (sram_we_no),
    .oe_no       (sram_oe_no)
  );

  sram4_chk #(.DATA_W(DATA_W), .ERR_CYCLES(ERR_CYCLES)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .phase_i  (phase),
    .wr_i     (wr),
    .vfy_i    (vfy),
    .dq_i     (sram_dq_i),
    .wd_i     (sram_dq_o),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid_o),
    .err_o    (err_o)
  );
endmodule

// File: rtl/sram4_ctrl_sva.sv
module sram4_ctrl_sva #(
  parameter int ADDR_W = 18
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ready_o,
  input logic              rvalid_o,
  input logic              err_o,
  input logic [ADDR_W-1:0] sram_addr_o,
  input logic              sram_dq_oe_o,
  input logic              sram_we_no,
  input logic              sram_oe_no
);
  a_r10_strobes_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!sram_we_no && !sram_oe_no));

  a_r10_drive_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_dq_oe_o |-> !sram_we_no);

  a_r2_we_min_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sram_we_no) |=> !sram_we_no);

  a_r2_we_max_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_we_no && !$past(sram_we_no)) |=> sram_we_no);

  a_r5_rvalid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);

  a_r7_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> $stable(sram_addr_o));

  a_r9_err_in_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> !sram_oe_no);
endmodule

bind sram4_ctrl sram4_ctrl_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ready_o      (ready_o),
  .rvalid_o     (rvalid_o),
  .err_o        (err_o),
  .sram_addr_o  (sram_addr_o),
  .sram_dq_oe_o (sram_dq_oe_o),
  .sram_we_no   (sram_we_no),
  .sram_oe_no   (sram_oe_no)
);

// File: tb/sram4_ctrl_tb.sv
`timescale 1ns/1ps
module sram4_ctrl_tb;
  localparam int AW = 10;
  localparam int DW = 16;
  localparam int EC = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_i = 1'b0, we_i = 1'b0, selfcheck_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic          ready_o, rvalid_o, err_o, dq_oe, we_n, oe_n;
  logic [DW-1:0] rdata_o, dq_o, dq_i;
  logic [AW-1:0] sram_addr;

  logic [DW-1:0] mem [1024];
  logic [DW-1:0] exp_mem [1024];
  logic [DW-1:0] exp_q [$];
  logic          corrupt = 1'b0;
  int            n_chk = 0, n_fail = 0, cyc = 0;

  always #4 clk = ~clk;

  sram4_ctrl #(.ADDR_W(AW), .DATA_W(DW), .ERR_CYCLES(EC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .selfcheck_i(selfcheck_i), .ready_o(ready_o),
    .rdata_o(rdata_o), .rvalid_o(rvalid_o), .err_o(err_o),
    .sram_addr_o(sram_addr), .sram_dq_o(dq_o), .sram_dq_oe_o(dq_oe),
    .sram_dq_i(dq_i), .sram_we_no(we_n), .sram_oe_no(oe_n)
  );

  // memory model
  always @(posedge clk) if (!we_n && dq_oe) mem[sram_addr] <= dq_o;
  always_comb dq_i = oe_n ? '1 : (mem[sram_addr] ^ {{(DW-1){1'b0}}, corrupt});

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rvalid_o) begin
      if (exp_q.size() == 0) chk(1'b0, "R8", "unexpected rvalid", 32'(rdata_o), 32'(0));
      else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        chk(rdata_o == e, "R5", "read data", 32'(rdata_o), 32'(e));
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      report();
      $finish;
    end
  end

  // one access; returns at the negedge inside phase 4
  task automatic access(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input bit sc, input bit stray);
    while (!ready_o) @(negedge clk);
    req_i = 1'b1; we_i = we; addr_i = a; wdata_i = d; selfcheck_i = sc;
    @(negedge clk);
    req_i = 1'b0; we_i = !we; addr_i = ~a; wdata_i = ~d; selfcheck_i = 1'b0;
    if (we) exp_mem[a] = d; else exp_q.push_back(exp_mem[a]);
    chk(sram_addr == a, "R7", "ph1 addr", 32'(sram_addr), 32'(a));
    chk(we_n && !dq_oe, "R2", "ph1 we_n/oe", {we_n, dq_oe}, 32'b10);
    chk(oe_n == we, "R3", "ph1 oe_n", 32'(oe_n), 32'(we));
    chk(!ready_o, "R4", "ph1 ready", 32'(ready_o), 32'(0));
    if (stray) begin req_i = 1'b1; addr_i = a + 1'b1; end
    @(negedge clk);
    req_i = 1'b0;
    chk(sram_addr == a, stray ? "R6" : "R7", "ph2 addr", 32'(sram_addr), 32'(a));
    if (we) begin
      chk(!we_n && dq_oe && oe_n, "R2", "ph2 strobes", {we_n, dq_oe, oe_n}, 32'b011);
      chk(dq_o == d, "R7", "ph2 dq", 32'(dq_o), 32'(d));
    end else
      chk(we_n && !dq_oe && !oe_n, "R3", "ph2 strobes", {we_n, dq_oe, oe_n}, 32'b100);
    @(negedge clk);
    chk(!ready_o, "R4", "ph3 ready", 32'(ready_o), 32'(0));
    if (we) chk(!we_n && dq_oe && dq_o == d, "R2", "ph3 hold", {we_n, dq_oe}, 32'b01);
    else    chk(!oe_n && !dq_oe, "R3", "ph3 strobes", {oe_n, dq_oe}, 32'b00);
    @(negedge clk);
    chk(ready_o == !(we && sc), sc ? "R8" : "R4", "ph4 ready", 32'(ready_o), 32'(!(we && sc)));
    if (we) chk(we_n && !dq_oe && oe_n, "R2", "ph4 strobes", {we_n, dq_oe, oe_n}, 32'b101);
    else    chk(!oe_n && we_n, "R3", "ph4 strobes", {oe_n, we_n}, 32'b01);
  endtask

  // self-check read-back after a write with sc=1
  task automatic verify(input logic [AW-1:0] a, input bit bad);
    for (int p = 1; p <= 4; p++) begin
      @(negedge clk);
      chk(!oe_n && we_n && sram_addr == a && !rvalid_o, "R8", "verify read",
          {oe_n, we_n, rvalid_o}, 32'b010);
    end
    chk(err_o == bad, "R9", "err at verify ph4", 32'(err_o), 32'(bad));
    begin
      int hi = 0;
      while (err_o && hi < 100) begin hi++; @(negedge clk); end
      if (bad) chk(hi == EC, "R9", "err width", 32'(hi), 32'(EC));
      else begin
        repeat (EC + 2) begin
          @(negedge clk);
          chk(!err_o, "R9", "no err on match", 32'(err_o), 32'(0));
        end
      end
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) begin mem[i] = '0; exp_mem[i] = '0; end
    repeat (3) @(negedge clk);
    chk(we_n && oe_n && !dq_oe && ready_o && !rvalid_o && !err_o, "R1", "in reset",
        {we_n, oe_n, dq_oe, ready_o, rvalid_o, err_o}, 32'b110100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(we_n && oe_n && !dq_oe && ready_o, "R1", "after reset",
        {we_n, oe_n, dq_oe, ready_o}, 32'b1101);

    // back-to-back write then read (R4)
    access(1'b1, 10'd5, 16'hA5A5, 1'b0, 1'b0);
    access(1'b0, 10'd5, '0, 1'b0, 1'b0);
    access(1'b1, 10'd0, 16'h0000, 1'b0, 1'b0);
    access(1'b1, 10'h3FF, 16'hFFFF, 1'b0, 1'b0);
    access(1'b1, 10'h155, 16'h1234, 1'b0, 1'b0);
    access(1'b0, 10'h3FF, '0, 1'b0, 1'b0);
    access(1'b0, 10'h155, '0, 1'b0, 1'b0);
    access(1'b0, 10'd0, '0, 1'b0, 1'b0);
    idle(2);

    // stray request while busy (R6)
    access(1'b0, 10'd5, '0, 1'b0, 1'b1);
    idle(1);
    chk(we_n && oe_n && ready_o, "R6", "no access after stray", {we_n, oe_n, ready_o}, 32'b111);
    idle(1);

    // rdata held through a later write (R5)
    access(1'b1, 10'd7, 16'h7777, 1'b0, 1'b0);
    idle(1);
    chk(rdata_o == 16'hA5A5, "R5", "rdata held", 32'(rdata_o), 32'hA5A5);

    // self-check, matching
    access(1'b1, 10'd9, 16'h0F0F, 1'b1, 1'b0);
    verify(10'd9, 1'b0);
    // self-check, forced mismatch
    corrupt = 1'b1;
    access(1'b1, 10'd11, 16'hBEEF, 1'b1, 1'b0);
    verify(10'd11, 1'b1);
    corrupt = 1'b0;
    idle(2);

    // reset in the middle of a write (R1)
    req_i = 1'b1; we_i = 1'b1; addr_i = 10'd5; wdata_i = 16'hDEAD;
    @(negedge clk);
    req_i = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(we_n && oe_n && !dq_oe, "R1", "reset aborts", {we_n, oe_n, dq_oe}, 32'b110);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready_o, "R1", "ready after abort", 32'(ready_o), 32'(1));
    access(1'b0, 10'd5, '0, 1'b0, 1'b0);
    idle(3);
    chk(exp_q.size() == 0, "R5", "all reads returned", 32'(exp_q.size()), 32'(0));
    report();
    $finish;
  end
endmodule